// File: doc/BRIEF.md
# Conditional Branch Resolver

This block decides, for one conditional branch per cycle, whether the branch is taken, where control goes next, and whether the delay-slot instruction behind it must be squashed. It takes the 32-bit instruction word and the PC of the branch. It also takes the four integer condition flags, the two-bit floating-point compare code, and a class input that says whether the branch tests the integer flags or the floating compare code. A decode stage feeds it. The outputs are registered once and go to the fetch logic.

The 4-bit condition field is split. Its top bit inverts the result of one of eight base tests chosen by the lower three bits. When the branch is taken, the next-next PC is the branch PC plus the scaled, sign-extended word displacement. When it is not taken, the next-next PC is the branch PC plus 8. The delayed-branch squash rule applies: an annulling branch-always squashes its slot, an untaken annulling branch squashes its slot, and a taken annulling conditional branch does not. A floating branch issued while the floating unit is switched off or absent raises a disabled-unit trap flag instead of branching. The block also outputs the integer condition result on its own, so the same logic can serve the trap-on-condition instruction.

Top module: `brcond_unit`

## Requirements
- R1: The condition field is instruction bits 28:25. Bits 27:25 select a base test, and bit 28 set inverts that base test.
- R2: The flags input carries N on bit 3, Z on bit 2, V on bit 1 and C on bit 0. The integer base tests for selectors 0..7 are: false, Z, Z or (N xor V), N xor V, C or Z, C, N, V.
- R3: The floating compare code is 0 equal, 1 less, 2 greater, 3 unordered. The floating base tests for selectors 0..7 are: false, code not 0, code 1 or 2, code 1 or 3, code 1, code 2 or 3, code 2, code 3.
- R4: The target is the branch PC plus the sign-extended 22-bit field in bits 21:0 shifted left by two, computed modulo 2^32.
- R5: next_pc equals the target when the branch is taken, and the branch PC plus 8 otherwise.
- R6: The annul bit is instruction bit 29. With it set, the slot is squashed when the condition field is 8 (always) or when the branch is not taken. A taken branch with any other condition value is never squashed, and with bit 29 clear nothing is squashed.
- R7: A floating branch (is_fp=1) with fp_enable=0 or fpu_present=0 sets fp_trap. It forces taken=0 and annul=0 regardless of bit 29. fp_enable and fpu_present have no effect on integer branches.
- R8: icc_true gives the integer condition result (R1, R2) for every instruction word, whatever the class input.
- R9: All outputs appear one clock after the inputs are presented. While rst_n is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn | input | 32 | Branch instruction word |
| pc | input | 32 | Address of the branch |
| flags | input | 4 | Integer flags {N,Z,V,C} |
| fcc | input | 2 | Floating compare code |
| is_fp | input | 1 | 1 selects the floating test, 0 the integer test |
| fp_enable | input | 1 | Floating unit enabled |
| fpu_present | input | 1 | Floating unit fitted |
| taken | output | 1 | Branch taken |
| annul | output | 1 | Squash the delay-slot instruction |
| target | output | 32 | Displacement target |
| next_pc | output | 32 | Selected next-next PC |
| fp_trap | output | 1 | Floating branch with the unit disabled or absent |
| icc_true | output | 1 | Integer condition result |

## Verification
The assertions check, on every cycle, the relations that hold between the outputs and the inputs of the previous cycle. They cover the squash rule for taken branches, the choice of next_pc between target and sequential address, the quiet outputs and the cause of a floating trap, and the fact that a never-condition integer branch is never taken. The correct truth value of each of the sixteen conditions under every flag pattern and every compare code can only be shown by the bench. The same holds for the arithmetic of the displacement at its extremes and for the reset values, which the bench checks against values it computes on its own.

// File: rtl/brc_pkg.sv
package brc_pkg;

  // Integer base test selected by bits 27:25; flags = {N,Z,V,C}
  function automatic logic icc_base(input logic [2:0] sel, input logic [3:0] flags);
    logic n, z, v, c;
    {n, z, v, c} = flags;
    case (sel)
      3'd0:    return 1'b0;
      3'd1:    return z;
      3'd2:    return z | (n ^ v);
      3'd3:    return n ^ v;
      3'd4:    return c | z;
      3'd5:    return c;
      3'd6:    return n;
      default: return v;
    endcase
  endfunction

  // Set of compare codes (bit k = code k) for which a floating base test holds
  function automatic logic [3:0] fcc_set(input logic [2:0] sel);
    case (sel)
      3'd0:    return 4'b0000;
      3'd1:    return 4'b1110;
      3'd2:    return 4'b0110;
      3'd3:    return 4'b1010;
      3'd4:    return 4'b0010;
      3'd5:    return 4'b1100;
      3'd6:    return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  // Squash decision for the delay slot
  function automatic logic squash(input logic abit, input logic tk, input logic [3:0] cond);
    return abit & (~tk | (cond == 4'b1000));
  endfunction

endpackage

// File: rtl/brc_icc_eval.sv
module brc_icc_eval (
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       result
);
  import brc_pkg::*;
  logic base_hit;
  always_comb begin
    base_hit = icc_base(cond[2:0], flags);
    result   = base_hit ^ cond[3];
  end
endmodule

// File: rtl/brc_fcc_eval.sv
module brc_fcc_eval #(
  parameter int FCC_W = 2
) (
  input  logic [3:0]       cond,
  input  logic [FCC_W-1:0] fcc,
  output logic             result
);
  import brc_pkg::*;
  localparam int NCODES = 1 << FCC_W;

  logic [NCODES-1:0] code_hit;
  logic [3:0]        member;

  for (genvar k = 0; k < NCODES; k++) begin : g_code
    assign code_hit[k] = (fcc == FCC_W'(k));
  end

  always_comb begin
    member = fcc_set(cond[2:0]);
    result = (|(code_hit & member[NCODES-1:0])) ^ cond[3];
  end
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 22,
  parameter int WORD_SH  = 2,
  parameter int SEQ_STEP = 8
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] seq_pc
);
  localparam int EXT_W = ADDR_W - DISP_W;
  logic [ADDR_W-1:0] offset;
  always_comb begin
    offset = {{EXT_W{disp[DISP_W-1]}}, disp} << WORD_SH;
    target = pc + offset;
    seq_pc = pc + ADDR_W'(SEQ_STEP);
  end
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int DISP_W = 22,
  parameter int FCC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] pc,
  input  logic [3:0]        flags,
  input  logic [FCC_W-1:0]  fcc,
  input  logic              is_fp,
  input  logic              fp_enable,
  input  logic              fpu_present,
  output logic              taken,
  output logic              annul,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc,
  output logic              fp_trap,
  output logic              icc_true
);
  import brc_pkg::*;

  localparam int COND_LSB = 25;
  localparam int ABIT     = 29;

  logic [3:0]        cond;
  logic              a_bit;
  logic              icc_hit, fcc_hit, fp_off;
  logic              tk_d, an_d;
  logic [ADDR_W-1:0] tgt_d, seq_d, npc_d;

  assign cond  = insn[COND_LSB +: 4];
  assign a_bit = insn[ABIT];

  brc_icc_eval u_icc (.cond(cond), .flags(flags), .result(icc_hit));

  brc_fcc_eval #(.FCC_W(FCC_W)) u_fcc (.cond(cond), .fcc(fcc), .result(fcc_hit));

  brc_target_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc(pc), .disp(insn[DISP_W-1:0]), .target(tgt_d), .seq_pc(seq_d)
  );

  always_comb begin
    fp_off = is_fp & ~(fp_enable & fpu_present);
    tk_d   = fp_off ? 1'b0 : (is_fp ? fcc_hit : icc_hit);
    an_d   = fp_off ? 1'b0 : squash(a_bit, tk_d, cond);
    npc_d  = tk_d ? tgt_d : seq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken    <= 1'b0;
      annul    <= 1'b0;
      target   <= '0;
      next_pc  <= '0;
      fp_trap  <= 1'b0;
      icc_true <= 1'b0;
    end else begin
      taken    <= tk_d;
      annul    <= an_d;
      target   <= tgt_d;
      next_pc  <= npc_d;
      fp_trap  <= fp_off;
      icc_true <= icc_hit;
    end
  end
endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int FCC_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INSN_W-1:0] insn,
  input logic [ADDR_W-1:0] pc,
  input logic              is_fp,
  input logic              fp_enable,
  input logic              fpu_present,
  input logic              taken,
  input logic              annul,
  input logic [ADDR_W-1:0] target,
  input logic [ADDR_W-1:0] next_pc,
  input logic              fp_trap
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_TAKEN_SQUASH_ONLY_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && taken && annul) |-> ($past(insn[28:25]) == 4'b1000)); // R6

  AST_UNTAKEN_ANNUL_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !taken && !fp_trap) |-> (annul == $past(insn[29]))); // R6

  AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !taken) |-> (next_pc == $past(pc) + ADDR_W'(8))); // R5

  AST_TAKEN_GOES_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && taken) |-> (next_pc == target)); // R5

  AST_FPTRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fp_trap |-> (!taken && !annul)); // R7

  AST_FPTRAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && fp_trap) |-> ($past(is_fp) && !($past(fp_enable) && $past(fpu_present)))); // R7

  AST_NEVER_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(insn[28:25]) == 4'b0000) |-> !taken); // R1
endmodule

bind brcond_unit brcond_unit_chk #(.ADDR_W(ADDR_W), .INSN_W(INSN_W), .FCC_W(FCC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn(insn), .pc(pc), .is_fp(is_fp),
  .fp_enable(fp_enable), .fpu_present(fpu_present), .taken(taken),
  .annul(annul), .target(target), .next_pc(next_pc), .fp_trap(fp_trap)
);

// File: tb/brcond_unit_test.sv
module brcond_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] insn, pc;
  logic [3:0]  flags;
  logic [1:0]  fcc;
  logic        is_fp, fp_enable, fpu_present;
  logic        taken, annul, fp_trap, icc_true;
  logic [31:0] target, next_pc;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  brcond_unit uut (
    .clk(clk), .rst_n(rst_n), .insn(insn), .pc(pc), .flags(flags), .fcc(fcc),
    .is_fp(is_fp), .fp_enable(fp_enable), .fpu_present(fpu_present),
    .taken(taken), .annul(annul), .target(target), .next_pc(next_pc),
    .fp_trap(fp_trap), .icc_true(icc_true)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [31:0] p;
    logic [3:0]  f;
    logic [1:0]  c;
    logic        fp, en, ok;
    logic        e_tk, e_an;
    logic [31:0] e_npc;
    logic        e_trap, e_icc;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h1000_0004, 32'h0000_1000, 4'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_1010, 1'b0, 1'b1},
    '{32'h303F_FFFF, 32'h0000_2000, 4'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_1FFC, 1'b0, 1'b1},
    '{32'h2200_0010, 32'h0000_0100, 4'h4, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0140, 1'b0, 1'b1},
    '{32'h2200_0010, 32'h0000_0100, 4'h0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0108, 1'b0, 1'b0},
    '{32'h2000_0005, 32'h0000_0400, 4'hF, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_0408, 1'b0, 1'b0},
    '{32'h0820_0000, 32'h0100_0000, 4'h0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0080_0000, 1'b0, 1'b0},
    '{32'h0820_0000, 32'h0100_0000, 4'h0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0100_0008, 1'b1, 1'b0},
    '{32'h2E00_0008, 32'h0000_0050, 4'h0, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0058, 1'b1, 1'b0}
  };

  // Integer condition written per named condition value
  function automatic logic ref_icc(input logic [3:0] cd, input logic [3:0] fl);
    logic n = fl[3], z = fl[2], v = fl[1], c = fl[0];
    case (cd)
      4'd0:  return 1'b0;          4'd8:  return 1'b1;
      4'd1:  return z;             4'd9:  return !z;
      4'd2:  return z || (n != v); 4'd10: return !z && (n == v);
      4'd3:  return n != v;        4'd11: return n == v;
      4'd4:  return c || z;        4'd12: return !c && !z;
      4'd5:  return c;             4'd13: return !c;
      4'd6:  return n;             4'd14: return !n;
      default: return (cd == 4'd7) ? v : !v;
    endcase
  endfunction

  function automatic logic ref_fcc(input logic [3:0] cd, input logic [1:0] k);
    logic e = (k == 0), l = (k == 1), g = (k == 2), u = (k == 3);
    logic b;
    case (cd[2:0])
      3'd0: b = 1'b0;   3'd1: b = l || g || u;
      3'd2: b = l || g; 3'd3: b = l || u;
      3'd4: b = l;      3'd5: b = g || u;
      3'd6: b = g;      default: b = u;
    endcase
    if (e && cd[2:0] == 3'd1) b = 1'b0;
    return cd[3] ? !b : b;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] p, input logic [3:0] f,
                       input logic [1:0] c, input logic fp, input logic en, input logic ok);
    @(negedge clk);
    insn = w; pc = p; flags = f; fcc = c; is_fp = fp; fp_enable = en; fpu_present = ok;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; insn = 32'h1000_0004; pc = 32'h1234; flags = 4'hF; fcc = 0;
    is_fp = 0; fp_enable = 1; fpu_present = 1;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero while reset is active
    check("R9 reset", {taken, annul, fp_trap, icc_true, next_pc, target[27:0]}, 64'd0);
    rst_n = 1'b1;

    // table of directed vectors (R1 R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].w, VECS[i].p, VECS[i].f, VECS[i].c, VECS[i].fp, VECS[i].en, VECS[i].ok);
      check("R6 R7 vector", {taken, annul, fp_trap, icc_true, next_pc},
            {VECS[i].e_tk, VECS[i].e_an, VECS[i].e_trap, VECS[i].e_icc, VECS[i].e_npc});
    end

    // R2 R8: all 16 conditions x all flag patterns, class input set to floating for R8
    for (int cd = 0; cd < 16; cd++) begin
      for (int fl = 0; fl < 16; fl++) begin
        logic       a   = fl[0] ^ cd[1];
        logic       tk  = ref_icc(4'(cd), 4'(fl));
        logic [31:0] w  = {2'b00, a, 4'(cd), 3'b010, 22'h00_0020};
        logic [31:0] p  = 32'h0000_8000 + 32'(cd * 64);
        apply(w, p, 4'(fl), 2'd0, 1'b0, 1'b1, 1'b1);
        check("R2 int taken", {63'd0, taken}, {63'd0, tk});
        check("R6 int annul", {63'd0, annul}, {63'd0, a && (!tk || cd == 8)});
        check("R5 int next_pc", {32'd0, next_pc}, {32'd0, tk ? p + 32'h80 : p + 32'd8});
        apply(w, p, 4'(fl), 2'd2, 1'b1, 1'b1, 1'b1);
        check("R8 icc_true under fp class", {63'd0, icc_true}, {63'd0, tk});
      end
    end

    // R3: all 16 conditions x all compare codes
    for (int cd = 0; cd < 16; cd++) begin
      for (int k = 0; k < 4; k++) begin
        logic        a  = 1'b1;
        logic        tk = ref_fcc(4'(cd), 2'(k));
        logic [31:0] w  = {2'b00, a, 4'(cd), 3'b110, 22'h3F_FFFE};
        apply(w, 32'h0000_0100, 4'h0, 2'(k), 1'b1, 1'b1, 1'b1);
        check("R3 fp taken", {63'd0, taken}, {63'd0, tk});
        check("R6 fp annul", {63'd0, annul}, {63'd0, !tk || cd == 8});
        check("R4 fp target", {32'd0, target}, {32'd0, 32'h0000_00F8});
      end
    end

    // R7: enables have no effect on an integer branch
    apply(32'h1000_0010, 32'h0000_0200, 4'h0, 2'd0, 1'b0, 1'b0, 1'b0);
    check("R7 int ignores fp enables", {61'd0, taken, fp_trap, annul}, {61'd0, 3'b100});

    // R4: largest positive displacement with wrap past the top of the address space
    apply(32'h101F_FFFF, 32'hFFFF_FF00, 4'h0, 2'd0, 1'b0, 1'b1, 1'b1);
    check("R4 max positive disp", {32'd0, target}, {32'd0, 32'hFFFF_FF00 + 32'h007F_FFFC});

    // R9: one-cycle latency, output still shows the previous branch before the edge
    @(negedge clk);
    insn = 32'h0200_0004; pc = 32'h40; flags = 4'h0; is_fp = 0;
    #1;
    check("R9 latency hold", {63'd0, taken}, {63'd0, 1'b1});
    @(negedge clk);
    check("R9 latency update", {32'd0, next_pc}, {32'd0, 32'h48});

    // R9: reset in mid-run clears outputs
    apply(32'h1000_0004, 32'h0000_3000, 4'h0, 2'd0, 1'b0, 1'b1, 1'b1);
    rst_n = 1'b0;
    #2;
    check("R9 mid-run reset", {taken, annul, fp_trap, icc_true, next_pc[27:0], target}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule